// File: doc/BRIEF.md
# Four-Rail Supply Sequencer

This block is a synchronous sequencer for four power-rail enables. It takes four digital "rail good" flags from external undervoltage comparators and an active-low enable. Once the enable is active and every rail flag reads good at the same time, it switches the rail enables on one at a time in the fixed order A, B, C, D. Each step waits for that channel's programmed delay. When the enable is withdrawn, it switches them off in the order D, C, B, A, with a separate delay for each channel. All delays count ticks of an internal prescaler. With the default setting, one tick is 1 ms.

A sequence-done output, active low, stays asserted until a fixed hold interval has passed after the last rail came on. A shared wired-AND system-reset line is modelled as a pull-low output and a sensed input. The block pulls the line low while its own reset is asserted. When it sees a low that it did not cause, it turns every rail off and stays off until the line is released. Controllers on a common line therefore start and stop together.

A rail that goes bad shuts the whole group down at once. When the start conditions hold again, the full turn-on sequence runs again by itself. Every rail flag and the enable pass through a two-flop synchronizer and then a stability filter, so short spikes have no effect.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: No rail enable turns on unless the filtered enable is low and all four filtered rail flags are high at the same time.
- R2: Turn-on order is A (bit 0), B (bit 1), C (bit 2), D (bit 3). Channel k turns on once the channel below it is on and its on-delay (field k of `on_delay_i`, 16 bits, counted in prescaler ticks) has expired. A delay of zero turns it on in the next cycle. One tick is one clock cycle in every TICK_DIV.
- R3: With all rails on, a high filtered enable starts turn-off in the order D, C, B, A. Each channel waits for its own off-delay (field k of `off_delay_i`). The rail enables always form a contiguous block starting at bit 0.
- R4: When a channel's off-delay expires, every lower channel whose off-delay is zero turns off on the same clock edge, down to the first lower channel whose off-delay is not zero.
- R5: `seq_rst_n_o` is low from reset. It goes high only after all four enables are on and HOLD_TICKS further ticks have passed, and it goes low again whenever a sequence or a shutdown starts.
- R6: A low on any filtered rail flag while any enable is on, or while a sequence is running, clears all four enables on the next edge and pulls the shared line low.
- R7: In the released state, a low sensed on `sysrst_sense_i` while the block is not pulling clears all enables within two cycles and releases the pull. The enables stay off until the sensed line is high again.
- R8: After a fault or a latch-off has cleared and the start conditions hold, the whole turn-on sequence runs again without outside action.
- R9: A rail flag or the enable changes its filtered level only after the new level has been seen for FILT_LEN consecutive cycles past a two-flop synchronizer. Shorter pulses have no effect on the enables.
- R10: If the enable goes high during turn-on, no further channel turns on. The channels already on turn off in reverse order with their off-delays. If none is on, the block returns to idle.
- R11: `sysrst_pull_o` is high whenever the sequence-done output is asserted, except while latched off by an external low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_ok_i | input | NCH | Rail-good flags, bit 0 = rail A |
| enable_n_i | input | 1 | Active-low sequence enable |
| on_delay_i | input | NCH*DW | Per-channel on-delays in ticks, field k = bits k*DW +: DW |
| off_delay_i | input | NCH*DW | Per-channel off-delays in ticks, same layout |
| sysrst_sense_i | input | 1 | Sensed level of the shared system-reset line |
| rail_en_o | output | NCH | Rail enable outputs |
| seq_rst_n_o | output | 1 | Sequence-done, low while held in reset |
| sysrst_pull_o | output | 1 | High to pull the shared line low |

## Verification
Two pairs of functions can land on the same clock edge. The first is the expiry of one channel's off-delay together with the zero-delay cascade through the channels below it. The bench provokes this with two zero off-delays under a non-zero one and judges the first change of the enables, which must jump from all-on to A-only. The second is the entry into the released state together with the first cycle in which the block's own pull is gone but the line still reads low. This must not count as an external latch-off. A cycle-exact behavioural model, compared on every clock, judges it. The same model then judges an injected external low a few cycles later.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_RAMP_UP,
      PS_SETTLE,
      PS_ACTIVE,
      PS_RAMP_DN,
      PS_LATCHED
   } pseq_state_e;
endpackage

// File: rtl/pseq_tick_gen.sv
module pseq_tick_gen #(
   parameter int unsigned DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("pseq_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cnt_q <= '0;
         else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
         else                             cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));

      // R2: ticks are isolated single-cycle pulses
      assert_tick_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/pseq_glitch_filter.sv
module pseq_glitch_filter #(
   parameter int unsigned LEN     = 8,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

   if (LEN < 1) begin : g_bad_len
      $error("pseq_glitch_filter: LEN must be at least 1");
   end

   logic          sync1_q, sync2_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= RST_VAL;
         sync2_q <= RST_VAL;
      end else begin
         sync1_q <= raw_i;
         sync2_q <= sync1_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_o <= RST_VAL;
         run_q  <= '0;
      end else if (sync2_q == filt_o) begin
         run_q  <= '0;
      end else if (run_q == CW'(LEN - 1)) begin
         filt_o <= sync2_q;
         run_q  <= '0;
      end else begin
         run_q  <= run_q + 1'b1;
      end
   end

   if (LEN >= 2) begin : g_chk
      // R9: a new filtered level was present at the raw input on earlier edges
      assert_filter_settle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt_o) |-> ($past(raw_i, 2) == filt_o && $past(raw_i, 3) == filt_o));
   end
endmodule

// File: rtl/pseq_core.sv
module pseq_core
   import pwr_seq_pkg::*;
#(
   parameter int unsigned NCH        = 4,
   parameter int unsigned DW         = 16,
   parameter int unsigned HOLD_TICKS = 160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [NCH-1:0]    rail_ok_i,
   input  logic              en_n_i,
   input  logic              line_i,
   input  logic [NCH*DW-1:0] on_dly_i,
   input  logic [NCH*DW-1:0] off_dly_i,
   output logic [NCH-1:0]    en_o,
   output logic              rel_o,
   output logic              pull_o
);
   localparam int unsigned    IW      = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [IW-1:0]  TOP_IDX = IW'(NCH - 1);
   localparam logic [DW-1:0]  HOLD_W  = DW'(HOLD_TICKS);

   logic [DW-1:0] on_dly  [NCH];
   logic [DW-1:0] off_dly [NCH];

   for (genvar k = 0; k < NCH; k++) begin : g_unpack
      assign on_dly[k]  = on_dly_i[k*DW +: DW];
      assign off_dly[k] = off_dly_i[k*DW +: DW];
   end

   pseq_state_e   state_q, state_n;
   logic [IW-1:0] idx_q, idx_n;
   logic [DW-1:0] dcnt_q, dcnt_n;
   logic [NCH-1:0] en_d;
   logic          line_q, pull_hist_q;
   logic          all_ok, ext_req, chain;

   assign all_ok  = &rail_ok_i;
   assign ext_req = !line_q && !pull_hist_q;

   always_comb begin
      state_n = state_q;
      idx_n   = idx_q;
      dcnt_n  = dcnt_q;
      en_d    = en_o;
      chain   = 1'b0;
      unique case (state_q)
         PS_IDLE: begin
            if (all_ok && !en_n_i) begin
               state_n = PS_RAMP_UP;
               idx_n   = '0;
               dcnt_n  = '0;
            end
         end
         PS_LATCHED: begin
            if (line_q) state_n = PS_IDLE;
         end
         default: begin
            if (!all_ok) begin
               state_n = PS_IDLE;
               en_d    = '0;
               idx_n   = '0;
               dcnt_n  = '0;
            end else if (ext_req) begin
               state_n = PS_LATCHED;
               en_d    = '0;
               idx_n   = '0;
               dcnt_n  = '0;
            end else begin
               unique case (state_q)
                  PS_RAMP_UP: begin
                     if (en_n_i) begin
                        dcnt_n = '0;
                        if (idx_q == '0) begin
                           state_n = PS_IDLE;
                        end else begin
                           state_n = PS_RAMP_DN;
                           idx_n   = idx_q - 1'b1;
                        end
                     end else if (dcnt_q == on_dly[idx_q]) begin
                        en_d[idx_q] = 1'b1;
                        dcnt_n      = '0;
                        if (idx_q == TOP_IDX) state_n = PS_SETTLE;
                        else                  idx_n   = idx_q + 1'b1;
                     end else if (tick_i) begin
                        dcnt_n = dcnt_q + 1'b1;
                     end
                  end
                  PS_SETTLE: begin
                     if (en_n_i) begin
                        state_n = PS_RAMP_DN;
                        idx_n   = TOP_IDX;
                        dcnt_n  = '0;
                     end else if (dcnt_q == HOLD_W) begin
                        state_n = PS_ACTIVE;
                        dcnt_n  = '0;
                     end else if (tick_i) begin
                        dcnt_n = dcnt_q + 1'b1;
                     end
                  end
                  PS_ACTIVE: begin
                     if (en_n_i) begin
                        state_n = PS_RAMP_DN;
                        idx_n   = TOP_IDX;
                        dcnt_n  = '0;
                     end
                  end
                  PS_RAMP_DN: begin
                     if (dcnt_q == off_dly[idx_q]) begin
                        en_d[idx_q] = 1'b0;
                        dcnt_n      = '0;
                        chain       = 1'b1;
                        for (int j = int'(NCH) - 2; j >= 0; j--) begin
                           if (chain && j < int'(idx_q)) begin
                              if (off_dly[j] == '0) begin
                                 en_d[j] = 1'b0;
                              end else begin
                                 chain = 1'b0;
                                 idx_n = IW'(j);
                              end
                           end
                        end
                        if (chain) begin
                           state_n = PS_IDLE;
                           idx_n   = '0;
                        end
                     end else if (tick_i) begin
                        dcnt_n = dcnt_q + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PS_IDLE;
         idx_q       <= '0;
         dcnt_q      <= '0;
         en_o        <= '0;
         rel_o       <= 1'b0;
         pull_o      <= 1'b1;
         line_q      <= 1'b1;
         pull_hist_q <= 1'b1;
      end else begin
         state_q     <= state_n;
         idx_q       <= idx_n;
         dcnt_q      <= dcnt_n;
         en_o        <= en_d;
         rel_o       <= (state_n == PS_ACTIVE);
         pull_o      <= !(state_n == PS_ACTIVE || state_n == PS_LATCHED);
         line_q      <= line_i;
         pull_hist_q <= pull_o;
      end
   end

   // R2 / R3: enables always form a contiguous block from channel A upward
   for (genvar k = 1; k < NCH; k++) begin : g_ladder
      assert_ladder_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         en_o[k] |-> en_o[k-1]);
   end

   assert_start_gate_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o[0]) |-> $past(all_ok && !en_n_i));

   assert_release_all_on_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_o) |-> (&en_o));

   assert_fault_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!all_ok && state_q != PS_LATCHED) |=> (en_o == '0 && pull_o && !rel_o));

   assert_ext_latch_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_ACTIVE && all_ok && ext_req) |=> (en_o == '0 && !pull_o && !rel_o));

   assert_abandon_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RAMP_UP && en_n_i) |=> ((en_o & ~$past(en_o)) == '0));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
   parameter int unsigned NCH        = 4,
   parameter int unsigned DW         = 16,
   parameter int unsigned TICK_DIV   = 100000,
   parameter int unsigned FILT_LEN   = 8,
   parameter int unsigned HOLD_TICKS = 160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    rail_ok_i,
   input  logic              enable_n_i,
   input  logic [NCH*DW-1:0] on_delay_i,
   input  logic [NCH*DW-1:0] off_delay_i,
   input  logic              sysrst_sense_i,
   output logic [NCH-1:0]    rail_en_o,
   output logic              seq_rst_n_o,
   output logic              sysrst_pull_o
);
   if (NCH < 2) begin : g_bad_nch
      $error("pwr_seq_ctrl: NCH must be at least 2");
   end
   if (DW < 1 || DW > 31) begin : g_bad_dw
      $error("pwr_seq_ctrl: DW must lie in 1..31");
   end
   if (HOLD_TICKS >= (1 << DW)) begin : g_bad_hold
      $error("pwr_seq_ctrl: HOLD_TICKS does not fit in DW bits");
   end

   logic           tick;
   logic [NCH-1:0] rail_f;
   logic           en_n_f;

   pseq_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_rail_filt
      pseq_glitch_filter #(.LEN(FILT_LEN), .RST_VAL(1'b0)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (rail_ok_i[k]),
         .filt_o (rail_f[k])
      );
   end

   pseq_glitch_filter #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_en_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (enable_n_i),
      .filt_o (en_n_f)
   );

   pseq_core #(.NCH(NCH), .DW(DW), .HOLD_TICKS(HOLD_TICKS)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .rail_ok_i (rail_f),
      .en_n_i    (en_n_f),
      .line_i    (sysrst_sense_i),
      .on_dly_i  (on_delay_i),
      .off_dly_i (off_delay_i),
      .en_o      (rail_en_o),
      .rel_o     (seq_rst_n_o),
      .pull_o    (sysrst_pull_o)
   );
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
   localparam int DIV  = 4;
   localparam int FILT = 3;
   localparam int HOLD = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rail = 4'h0;
   logic        en_n = 1'b1;
   logic        ext_drv = 1'b0;
   logic [3:0]  outp_en;
   logic        seq_rel, pull;
   logic        line;
   // field k = channel k (A=0): on A=1 B=0 C=6 D=1, off A=1 B=0 C=0 D=2
   logic [63:0] on_bus  = {16'd1, 16'd6, 16'd0, 16'd1};
   logic [63:0] off_bus = {16'd2, 16'd0, 16'd0, 16'd1};
   int ond [4] = '{1, 0, 6, 1};
   int offd[4] = '{1, 0, 0, 2};

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign line = !(pull || ext_drv);

   pwr_seq_ctrl #(.NCH(4), .DW(16), .TICK_DIV(DIV), .FILT_LEN(FILT), .HOLD_TICKS(HOLD))
   i_pwr_seq_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .rail_ok_i      (rail),
      .enable_n_i     (en_n),
      .on_delay_i     (on_bus),
      .off_delay_i    (off_bus),
      .sysrst_sense_i (line),
      .rail_en_o      (outp_en),
      .seq_rst_n_o    (seq_rel),
      .sysrst_pull_o  (pull)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   // states: 0 idle, 1 turning on, 2 holding, 3 released, 4 turning off, 5 latched off
   int       m_div, m_st, m_idx, m_cnt;
   int       m_run[5];
   bit       m_d1[5], m_d2[5], m_f[5];
   bit [3:0] m_en;
   bit       m_rel, m_pull, m_sq, m_pd;

   task automatic model_reset();
      m_div = 0; m_st = 0; m_idx = 0; m_cnt = 0; m_en = '0;
      m_rel = 0; m_pull = 1; m_sq = 1; m_pd = 1;
      for (int i = 0; i < 5; i++) begin
         m_run[i] = 0;
         m_d1[i] = (i == 4); m_d2[i] = (i == 4); m_f[i] = (i == 4);
      end
   endtask

   task automatic model_step();
      bit tk, ok, enn, ex, ln, ch;
      bit raw[5];
      int ns, ni, nc;
      bit [3:0] ne;
      tk  = (m_div == DIV - 1);
      ok  = m_f[0] && m_f[1] && m_f[2] && m_f[3];
      enn = m_f[4];
      ex  = !m_sq && !m_pd;
      ln  = !(m_pull || ext_drv);
      ns = m_st; ni = m_idx; nc = m_cnt; ne = m_en;
      if (m_st == 0) begin
         if (ok && !enn) begin ns = 1; ni = 0; nc = 0; end
      end else if (m_st == 5) begin
         if (m_sq) ns = 0;
      end else if (!ok) begin
         ns = 0; ni = 0; nc = 0; ne = '0;
      end else if (ex) begin
         ns = 5; ni = 0; nc = 0; ne = '0;
      end else if (m_st == 1) begin
         if (enn) begin
            nc = 0;
            if (m_idx == 0) ns = 0; else begin ns = 4; ni = m_idx - 1; end
         end else if (m_cnt == ond[m_idx]) begin
            ne[m_idx] = 1; nc = 0;
            if (m_idx == 3) ns = 2; else ni = m_idx + 1;
         end else if (tk) nc++;
      end else if (m_st == 2) begin
         if (enn) begin ns = 4; ni = 3; nc = 0; end
         else if (m_cnt == HOLD) begin ns = 3; nc = 0; end
         else if (tk) nc++;
      end else if (m_st == 3) begin
         if (enn) begin ns = 4; ni = 3; nc = 0; end
      end else if (m_st == 4) begin
         if (m_cnt == offd[m_idx]) begin
            ne[m_idx] = 0; nc = 0; ch = 1;
            for (int j = m_idx - 1; j >= 0 && ch; j--) begin
               if (offd[j] == 0) ne[j] = 0;
               else begin ch = 0; ni = j; end
            end
            if (ch) begin ns = 0; ni = 0; end
         end else if (tk) nc++;
      end
      m_div = tk ? 0 : m_div + 1;
      for (int i = 0; i < 4; i++) raw[i] = rail[i];
      raw[4] = en_n;
      for (int i = 0; i < 5; i++) begin
         if (m_d2[i] == m_f[i]) m_run[i] = 0;
         else if (m_run[i] == FILT - 1) begin m_f[i] = m_d2[i]; m_run[i] = 0; end
         else m_run[i]++;
         m_d2[i] = m_d1[i];
         m_d1[i] = raw[i];
      end
      m_pd = m_pull;
      m_sq = ln;
      m_st = ns; m_idx = ni; m_cnt = nc; m_en = ne;
      m_rel  = (ns == 3);
      m_pull = !(ns == 3 || ns == 5);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) model_reset();
      else model_step();
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 R3 R4 enables vs model", {28'd0, outp_en}, {28'd0, m_en});
         chk("R5 sequence-done vs model", {31'd0, seq_rel}, {31'd0, m_rel});
         chk("R11 line pull vs model",    {31'd0, pull},    {31'd0, m_pull});
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 60000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=%0d expected<=%0d", cyc, 60000);
         finish_up();
      end
   end

   task automatic wait_en(input logic [3:0] v, input int lim, input string req);
      int k = 0;
      while (outp_en !== v && k < lim) begin @(negedge clk); k++; end
      chk(req, {28'd0, outp_en}, {28'd0, v});
   endtask

   task automatic wait_rel(input int lim, input string req);
      int k = 0;
      while (seq_rel !== 1'b1 && k < lim) begin @(negedge clk); k++; end
      chk(req, {31'd0, seq_rel}, 32'd1);
   endtask

   initial begin
      bit saw_c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 reset state done-output", {31'd0, seq_rel}, 32'd0);
      chk("R11 reset state pull", {31'd0, pull}, 32'd1);
      chk("R1 reset state enables", {28'd0, outp_en}, 32'd0);

      // R1: three good rails are not enough
      rail = 4'b0111; en_n = 1'b0;
      repeat (40) @(negedge clk);
      chk("R1 missing rail blocks start", {28'd0, outp_en}, 32'd0);
      rail = 4'b1111;
      wait_en(4'hF, 300, "R2 full turn-on");
      chk("R5 held after last rail on", {31'd0, seq_rel}, 32'd0);
      wait_rel(300, "R5 release after hold");

      // R9: two-cycle dip is filtered out
      rail[1] = 1'b0; repeat (2) @(negedge clk); rail[1] = 1'b1;
      repeat (20) @(negedge clk);
      chk("R9 glitch ignored enables", {28'd0, outp_en}, 32'hF);
      chk("R9 glitch ignored done", {31'd0, seq_rel}, 32'd1);

      // R4 / R3: ordered turn-off with zero-delay cascade
      en_n = 1'b1;
      begin
         int k = 0;
         while (outp_en === 4'hF && k < 200) begin @(negedge clk); k++; end
      end
      chk("R4 D C B off on one edge", {28'd0, outp_en}, 32'h1);
      wait_en(4'h0, 200, "R3 turn-off complete");

      // R6 / R8: rail fault then automatic restart
      en_n = 1'b0;
      wait_en(4'hF, 300, "R8 restart after enable");
      wait_rel(300, "R5 release second run");
      rail[2] = 1'b0;
      wait_en(4'h0, 20, "R6 fault shuts all");
      chk("R6 pull during fault", {31'd0, pull}, 32'd1);
      rail[2] = 1'b1;
      wait_en(4'hF, 300, "R8 restart after fault");
      wait_rel(300, "R5 release after fault");

      // R7: external latch-off
      ext_drv = 1'b1;
      wait_en(4'h0, 10, "R7 external low shuts all");
      chk("R7 pull released while latched", {31'd0, pull}, 32'd0);
      repeat (30) @(negedge clk);
      chk("R7 stays off while line low", {28'd0, outp_en}, 32'd0);
      ext_drv = 1'b0;
      wait_en(4'hF, 300, "R7 R8 restart after line release");
      wait_rel(300, "R5 release after latch");

      // R10: abandon turn-on part way
      en_n = 1'b1;
      wait_en(4'h0, 200, "R3 second turn-off");
      en_n = 1'b0;
      wait_en(4'h3, 200, "R2 A and B on");
      en_n = 1'b1;
      saw_c = 1'b0;
      for (int k = 0; k < 200 && outp_en !== 4'h0; k++) begin
         @(negedge clk);
         if (outp_en[2]) saw_c = 1'b1;
      end
      chk("R10 no further channel after abandon", {31'd0, saw_c}, 32'd0);
      chk("R10 abandoned ramp ends off", {28'd0, outp_en}, 32'd0);
      repeat (10) @(negedge clk);
      finish_up();
   end
endmodule